// File: doc/BRIEF.md
# Binary-to-Ternary Cell Codec

This block sits between a (72,64) single-error-correcting, double-error-detecting (SECDED) code and an array of three-level memory cells. On the write path it takes a 72-bit protected word and cuts it into twenty-four 3-bit groups. Each group becomes a pair of cell levels, which gives 48 two-bit level codes per word. On the read path it takes 48 sensed levels, turns each pair back into 3 bits and rebuilds the 72-bit word for the error-correcting decoder downstream.

Cells keep three levels, at nominal log10 resistances of 3.0, 4.0 and 6.0. Drift only raises resistance, so a cell can only slip up by one level. The group map is chosen so that a one-step upward slip of any single cell into another used pair changes exactly one recovered bit. An ordinary binary SECDED code can then correct it. Of the nine possible pairs, eight are used. The ninth, and the unused sense code, are repaired and reported through a per-word flag.

Each path has a valid/ready handshake. The `REG_OUT` parameter selects either a purely combinational path or a single output register with one cycle of latency.

Top module: `tlc_codec`

## Requirements
- R1: Level codes are 2'b00 for level 0, 2'b01 for level 1 and 2'b10 for level 2. Group value to (high, low) levels: 000→(0,0), 001→(0,1), 011→(0,2), 010→(1,2), 110→(2,2), 111→(2,1), 101→(2,0), 100→(1,0).
- R2: Group k is word bits [3k+2:3k]. Its low symbol drives cell 2k and its high symbol drives cell 2k+1. Cell c occupies level-vector bits [2c+1:2c].
- R3: Decoding the encoder's output returns the original 72-bit word unchanged, with the invalid flag low.
- R4: If any single cell of an encoded word moves up by one level and the new pair is a used pair, the decoded word differs from the original in exactly one bit and the flag stays low.
- R5: A sensed pair (1,1) decodes to group value 100 and raises the invalid flag for that word. A word that contains no invalid pair or code reads back with the flag low.
- R6: A sensed level code 2'b11 decodes as level 2 and raises the invalid flag.
- R7: The encoder never emits level code 2'b11 and never emits the pair (1,1).
- R8: With `REG_OUT`=1, an input accepted on a clock edge appears at the output valid after that edge. While the output is valid and not accepted, its data holds steady and the input is not accepted.
- R9: After reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write word valid |
| wr_ready_o | output | 1 | Write word accepted |
| wr_data_i | input | 72 | Protected word to store |
| cell_valid_o | output | 1 | Cell levels valid |
| cell_ready_i | input | 1 | Cell levels taken |
| cell_lvl_o | output | 96 | 48 two-bit level codes |
| rd_valid_i | input | 1 | Sensed levels valid |
| rd_ready_o | output | 1 | Sensed levels accepted |
| rd_lvl_i | input | 96 | 48 sensed two-bit level codes |
| word_valid_o | output | 1 | Rebuilt word valid |
| word_ready_i | input | 1 | Rebuilt word taken |
| word_data_o | output | 72 | Rebuilt protected word |
| word_bad_o | output | 1 | Invalid pair or level code seen in this word |

## Verification
The bench builds the block with its defaults: a 72-bit word and `REG_OUT`=1. This lets it check the one-cycle latency and the hold-under-stall behaviour alongside the symbol map. The 72-bit width puts all 48 cells within reach of drift injection. This covers the group positions at both ends of the word and the two drift moves that land on the unused pair (1,1).

// File: rtl/tlc_codec_pkg.sv
package tlc_codec_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL0 = 2'b00;
  localparam lvl_t LVL1 = 2'b01;
  localparam lvl_t LVL2 = 2'b10;
  localparam lvl_t LVLX = 2'b11;
  localparam int unsigned GRP_W = 3;
  localparam int unsigned LVL_W = 2;
endpackage

// File: rtl/tlc_group_enc.sv
module tlc_group_enc
  import tlc_codec_pkg::*;
(
  input  logic [GRP_W-1:0] bits_i,
  output lvl_t             lo_o,
  output lvl_t             hi_o
);
  always_comb begin
    unique case (bits_i)
      3'b000:  begin hi_o = LVL0; lo_o = LVL0; end
      3'b001:  begin hi_o = LVL0; lo_o = LVL1; end
      3'b011:  begin hi_o = LVL0; lo_o = LVL2; end
      3'b010:  begin hi_o = LVL1; lo_o = LVL2; end
      3'b110:  begin hi_o = LVL2; lo_o = LVL2; end
      3'b111:  begin hi_o = LVL2; lo_o = LVL1; end
      3'b101:  begin hi_o = LVL2; lo_o = LVL0; end
      default: begin hi_o = LVL1; lo_o = LVL0; end // 3'b100
    endcase
  end
endmodule

// File: rtl/tlc_group_dec.sv
module tlc_group_dec
  import tlc_codec_pkg::*;
(
  input  lvl_t             lo_i,
  input  lvl_t             hi_i,
  output logic [GRP_W-1:0] bits_o,
  output logic             bad_o
);
  lvl_t lo_n, hi_n;
  logic code_bad;

  // unused sense code folds onto the top level
  assign lo_n     = (lo_i == LVLX) ? LVL2 : lo_i;
  assign hi_n     = (hi_i == LVLX) ? LVL2 : hi_i;
  assign code_bad = (lo_i == LVLX) || (hi_i == LVLX);

  always_comb begin
    bad_o = code_bad;
    unique case ({hi_n, lo_n})
      {LVL0, LVL0}: bits_o = 3'b000;
      {LVL0, LVL1}: bits_o = 3'b001;
      {LVL0, LVL2}: bits_o = 3'b011;
      {LVL1, LVL2}: bits_o = 3'b010;
      {LVL2, LVL2}: bits_o = 3'b110;
      {LVL2, LVL1}: bits_o = 3'b111;
      {LVL2, LVL0}: bits_o = 3'b101;
      {LVL1, LVL0}: bits_o = 3'b100;
      default: begin
        bits_o = 3'b100; // unused pair (1,1)
        bad_o  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/tlc_out_stage.sv
module tlc_out_stage #(
  parameter int unsigned W   = 8,
  parameter bit          REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  if (REG) begin : g_reg
    logic         v_q;
    logic [W-1:0] d_q;
    assign in_ready_o  = !v_q || out_ready_i;
    assign out_valid_o = v_q;
    assign out_data_o  = d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (in_ready_o) begin
        v_q <= in_valid_i;
        if (in_valid_i) d_q <= in_data_i;
      end
    end
  end else begin : g_comb
    assign in_ready_o  = out_ready_i;
    assign out_valid_o = in_valid_i;
    assign out_data_o  = in_data_i;
  end
endmodule

// File: rtl/tlc_codec.sv
module tlc_codec
  import tlc_codec_pkg::*;
#(
  parameter int unsigned WORD_W  = 72,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned N_GRP  = WORD_W / GRP_W,
  localparam int unsigned N_CELL = 2 * N_GRP,
  localparam int unsigned LV_W   = N_CELL * LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              cell_valid_o,
  input  logic              cell_ready_i,
  output logic [LV_W-1:0]   cell_lvl_o,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [LV_W-1:0]   rd_lvl_i,
  output logic              word_valid_o,
  input  logic              word_ready_i,
  output logic [WORD_W-1:0] word_data_o,
  output logic              word_bad_o
);
  logic [LV_W-1:0]   enc_lvl;
  logic [WORD_W-1:0] dec_word;
  logic [N_GRP-1:0]  dec_bad;

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    tlc_group_enc u_enc (
      .bits_i (wr_data_i[GRP_W*k +: GRP_W]),
      .lo_o   (enc_lvl[LVL_W*(2*k)   +: LVL_W]),
      .hi_o   (enc_lvl[LVL_W*(2*k+1) +: LVL_W])
    );
    tlc_group_dec u_dec (
      .lo_i   (rd_lvl_i[LVL_W*(2*k)   +: LVL_W]),
      .hi_i   (rd_lvl_i[LVL_W*(2*k+1) +: LVL_W]),
      .bits_o (dec_word[GRP_W*k +: GRP_W]),
      .bad_o  (dec_bad[k])
    );
  end

  tlc_out_stage #(.W(LV_W), .REG(REG_OUT)) u_wr_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (wr_valid_i),
    .in_ready_o  (wr_ready_o),
    .in_data_i   (enc_lvl),
    .out_valid_o (cell_valid_o),
    .out_ready_i (cell_ready_i),
    .out_data_o  (cell_lvl_o)
  );

  tlc_out_stage #(.W(WORD_W + 1), .REG(REG_OUT)) u_rd_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (rd_valid_i),
    .in_ready_o  (rd_ready_o),
    .in_data_i   ({|dec_bad, dec_word}),
    .out_valid_o (word_valid_o),
    .out_ready_i (word_ready_i),
    .out_data_o  ({word_bad_o, word_data_o})
  );
endmodule

// File: rtl/tlc_codec_chk.sv
module tlc_codec_chk #(
  parameter int unsigned N_CELL  = 48,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_valid_i,
  input logic                  wr_ready_o,
  input logic                  cell_valid_o,
  input logic                  cell_ready_i,
  input logic [2*N_CELL-1:0]   cell_lvl_o,
  input logic                  rd_valid_i,
  input logic                  rd_ready_o,
  input logic                  word_valid_o,
  input logic                  word_ready_i,
  input logic                  word_bad_o
);
  logic any_x;
  always_comb begin
    any_x = 1'b0;
    for (int c = 0; c < N_CELL; c++) any_x |= (cell_lvl_o[2*c +: 2] == 2'b11);
  end

  // R7: encoder output never carries the unused code
  a_r7_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_valid_o |-> !any_x);

  if (REG_OUT) begin : g_reg
    // R8: accepted input is presented on the next cycle
    a_r8_wr_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_i && wr_ready_o) |=> cell_valid_o);
    a_r8_rd_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_i && rd_ready_o) |=> word_valid_o);
    // R8: stalled outputs hold
    a_r8_cell_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cell_valid_o && !cell_ready_i) |=> (cell_valid_o && $stable(cell_lvl_o)));
    a_r8_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_bad_o)));
  end
endmodule

bind tlc_codec tlc_codec_chk #(.N_CELL(N_CELL), .REG_OUT(REG_OUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .wr_ready_o   (wr_ready_o),
  .cell_valid_o (cell_valid_o),
  .cell_ready_i (cell_ready_i),
  .cell_lvl_o   (cell_lvl_o),
  .rd_valid_i   (rd_valid_i),
  .rd_ready_o   (rd_ready_o),
  .word_valid_o (word_valid_o),
  .word_ready_i (word_ready_i),
  .word_bad_o   (word_bad_o)
);

// File: tb/tlc_codec_tb.sv
module tlc_codec_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int W  = 72;
  localparam int NG = W / 3;
  localparam int NC = 2 * NG;
  localparam int LV = 2 * NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready, cell_valid, cell_ready = 1'b1;
  logic [W-1:0]  wr_data = '0;
  logic [LV-1:0] cell_lvl;
  logic rd_valid = 1'b0, rd_ready, word_valid, word_ready = 1'b1, word_bad;
  logic [LV-1:0] rd_lvl = '0;
  logic [W-1:0]  word_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlc_codec #(.WORD_W(W), .REG_OUT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .cell_valid_o(cell_valid), .cell_ready_i(cell_ready), .cell_lvl_o(cell_lvl),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_lvl_i(rd_lvl),
    .word_valid_o(word_valid), .word_ready_i(word_ready),
    .word_data_o(word_data), .word_bad_o(word_bad)
  );

  task automatic chk(input bit ok, input string req, input logic [LV-1:0] act, input logic [LV-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // requirement table: {hi, lo} level codes
  function automatic logic [3:0] ref_pair(input logic [2:0] b);
    case (b)
      3'b000: return 4'b00_00;
      3'b001: return 4'b00_01;
      3'b011: return 4'b00_10;
      3'b010: return 4'b01_10;
      3'b110: return 4'b10_10;
      3'b111: return 4'b10_01;
      3'b101: return 4'b10_00;
      default: return 4'b01_00;
    endcase
  endfunction

  function automatic logic [LV-1:0] ref_enc(input logic [W-1:0] d);
    logic [LV-1:0] r;
    for (int k = 0; k < NG; k++) r[4*k +: 4] = ref_pair(d[3*k +: 3]);
    return r;
  endfunction

  function automatic logic [W:0] ref_dec(input logic [LV-1:0] l);
    logic [W-1:0] w;
    logic bad;
    bad = 1'b0;
    for (int k = 0; k < NG; k++) begin
      logic [1:0] hi, lo;
      hi = l[4*k+2 +: 2];
      lo = l[4*k +: 2];
      if (hi == 2'b11) begin hi = 2'b10; bad = 1'b1; end
      if (lo == 2'b11) begin lo = 2'b10; bad = 1'b1; end
      w[3*k +: 3] = 3'b100;
      if ({hi, lo} == 4'b0101) bad = 1'b1;
      for (int b = 0; b < 8; b++)
        if (ref_pair(3'(b)) == {hi, lo}) w[3*k +: 3] = 3'(b);
    end
    return {bad, w};
  endfunction

  task automatic do_enc(input logic [W-1:0] d, output logic [LV-1:0] l);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(cell_valid === 1'b1, "R8 enc valid", LV'(cell_valid), LV'(1));
    l = cell_lvl;
  endtask

  task automatic do_dec(input logic [LV-1:0] l, output logic [W-1:0] w, output logic bad);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_lvl   = l;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    chk(word_valid === 1'b1, "R8 dec valid", LV'(word_valid), LV'(1));
    w   = word_data;
    bad = word_bad;
  endtask

  task automatic t_reset;
    chk({cell_valid, word_valid, wr_ready, rd_ready} === 4'b0011, "R9 reset",
        LV'({cell_valid, word_valid, wr_ready, rd_ready}), LV'(4'b0011));
  endtask

  task automatic t_map;
    logic [LV-1:0] l;
    for (int v = 0; v < 8; v++) begin
      logic [W-1:0] d;
      bit no_x;
      for (int k = 0; k < NG; k++) d[3*k +: 3] = 3'(v);
      do_enc(d, l);
      chk(l === ref_enc(d), "R1 map", l, ref_enc(d));
      no_x = 1'b1;
      for (int c = 0; c < NC; c += 2)
        if (l[2*c +: 2] == 2'b11 || l[2*c+2 +: 2] == 2'b11 || l[2*c +: 4] == 4'b0101) no_x = 1'b0;
      chk(no_x, "R7 no code3/pair11", l, '0);
    end
  endtask

  task automatic t_pos;
    int ks[3] = '{0, 7, NG-1};
    logic [LV-1:0] l, e;
    foreach (ks[i]) begin
      logic [W-1:0] d;
      d = '0;
      d[3*ks[i] +: 3] = 3'b011; // low cell level 2, high cell level 0
      do_enc(d, l);
      e = '0;
      e[2*(2*ks[i]) +: 2] = 2'b10;
      chk(l === e, "R2 group position", l, e);
      d[3*ks[i] +: 3] = 3'b100; // high cell level 1, low cell level 0
      do_enc(d, l);
      e = '0;
      e[2*(2*ks[i]+1) +: 2] = 2'b01;
      chk(l === e, "R2 group position", l, e);
    end
  endtask

  task automatic t_round;
    logic [W-1:0] pats[4] = '{'0, '1, {9{8'hA5}}, {9{8'h5A}}};
    logic [LV-1:0] l;
    logic [W-1:0] w;
    logic bad;
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] d;
      if (i < 4) d = pats[i];
      else d = {$urandom(), $urandom(), $urandom()} >> 24;
      do_enc(d, l);
      do_dec(l, w, bad);
      chk(w === d && bad === 1'b0, "R3 round trip", LV'({bad, w}), LV'({1'b0, d}));
    end
  endtask

  task automatic t_drift;
    logic [LV-1:0] l, m;
    logic [W-1:0] w;
    logic bad;
    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] d;
      if (i == 0) for (int k = 0; k < NG; k++) d[3*k +: 3] = (k % 2) ? 3'b001 : 3'b100;
      else d = {$urandom(), $urandom(), $urandom()} >> 24;
      do_enc(d, l);
      for (int c = 0; c < NC; c++) begin
        if (l[2*c +: 2] < 2'b10) begin
          m = l;
          m[2*c +: 2] = l[2*c +: 2] + 2'b01;
          do_dec(m, w, bad);
          if (m[4*(c/2) +: 4] == 4'b0101)
            chk({bad, w} === ref_dec(m), "R5 pair11", LV'({bad, w}), LV'(ref_dec(m)));
          else
            chk(bad === 1'b0 && $countones(w ^ d) == 1, "R4 single bit",
                LV'({bad, w ^ d}), LV'(1));
        end
      end
      do_dec(l, w, bad);
      chk(bad === 1'b0 && w === d, "R5 flag clears", LV'({bad, w}), LV'({1'b0, d}));
    end
  endtask

  task automatic t_code3;
    logic [LV-1:0] l, m;
    logic [W-1:0] w;
    logic [W-1:0] d;
    logic bad;
    d = {9{8'h3C}};
    do_enc(d, l);
    for (int c = 0; c < NC; c += 13) begin
      m = l;
      m[2*c +: 2] = 2'b11;
      do_dec(m, w, bad);
      chk({bad, w} === ref_dec(m) && bad === 1'b1, "R6 code3", LV'({bad, w}), LV'(ref_dec(m)));
    end
  endtask

  task automatic t_stall;
    logic [W-1:0] a, b;
    logic [LV-1:0] la;
    a = {9{8'h96}};
    b = {9{8'h17}};
    cell_ready = 1'b0;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = a;
    @(posedge clk);
    @(negedge clk);
    la = cell_lvl;
    chk(cell_valid && !wr_ready, "R8 stall blocks input", LV'({cell_valid, wr_ready}), LV'(2'b10));
    wr_data = b;
    @(posedge clk);
    @(negedge clk);
    chk(cell_valid && cell_lvl === la && la === ref_enc(a), "R8 hold", cell_lvl, ref_enc(a));
    cell_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(cell_valid && cell_lvl === ref_enc(b), "R8 next word", cell_lvl, ref_enc(b));
    @(posedge clk);
    @(negedge clk);
    chk(!cell_valid, "R8 drained", LV'(cell_valid), '0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_pos();
    t_round();
    t_drift();
    t_code3();
    t_stall();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end
endmodule